// File: doc/BRIEF.md
# CPU Interrupt Acceptance Logic

This block sits between the group expanders and the processor core. Each of its twelve request lines takes single-cycle pulses from an expander. A pulse is latched into a pending flag for that line. On every cycle the block looks at the pending flags and decides whether a line is eligible. A line is eligible when its own enable bit is set, or when its debug enable bit is set while the core is in debug mode, and the global mask is clear.

When at least one line is eligible, the block takes the lowest-numbered one in a single atomic step. In that step it clears the line's pending flag and its enable bit, sets the global mask and drops the protected-register write enable. It also raises a take strobe that tells the core to save context. One cycle later it issues a vector request to the expander, carrying the same line number.

Software reaches the flags, the enables, the debug enables, the mask and the protected-write bit through a simple write port. The current state is driven on outputs for the rest of the core.

Top module: `irq_accept`

## Requirements
- R1: A pulse on `req_pulse_i[x]` sampled at a rising edge makes `flag_o[x]` read 1 after that edge.
- R2: A line is taken only if its flag is 1 and `mask_o` is 0 in the cycle before `take_o` rises, and either its `en_o` bit is 1 or (R3) its debug enable qualifies it. `take_o` is high for the single cycle after the edge that sampled the eligible state.
- R3: A `dbg_en_o` bit makes its line eligible only while `dbg_mode_i` is 1. With `dbg_mode_i` at 0 it has no effect on `take_o`.
- R4: The edge that raises `take_o` for line x also clears `en_o[x]` and sets `mask_o` to 1. `take_o` is never high in two consecutive cycles.
- R5: The edge that raises `take_o` also clears `prot_we_o`.
- R6: `vec_req_o` is high exactly one cycle after `take_o`, and `vec_idx_o` equals the `take_idx_o` of that take.
- R7: When several lines are eligible, `take_idx_o` is the lowest-numbered of them.
- R8: Taking line x clears `flag_o[x]`. If a new pulse arrives on line x at that same edge, the flag stays 1.
- R9: After reset, the flags, enables, debug enables, `prot_we_o`, `take_o` and `vec_req_o` are 0, and `mask_o` is 1.
- R10: Writes use `wr_sel_i` as follows. 0 sets the flags whose `wr_data_i` bits are 1. 1 clears the flags whose bits are 1. 2 loads the enables. 3 loads the debug enables. 4 loads the mask from `wr_data_i[0]`. 5 loads the protected-write bit from `wr_data_i[0]`. Every write takes effect at the edge where `wr_en_i` is sampled high. Pulses win over a flag clear. A take wins over a write to the bits it changes.
- R11: While `mask_o` is 1, no line is taken, whatever the flags and enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pulse_i | input | 12 | Request pulses, one bit per line |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register write select |
| wr_data_i | input | 12 | Register write data |
| dbg_mode_i | input | 1 | Core is in debug mode |
| take_o | output | 1 | Interrupt taken; save context |
| take_idx_o | output | 4 | Line number of the take |
| vec_req_o | output | 1 | Vector request to the expander |
| vec_idx_o | output | 4 | Line number of the vector request |
| flag_o | output | 12 | Pending flags |
| en_o | output | 12 | Line enables |
| dbg_en_o | output | 12 | Debug enables |
| mask_o | output | 1 | Global mask |
| prot_we_o | output | 1 | Protected-register write enable |

## Verification
Pulses and writes show up in the state outputs one edge after they are sampled. A take comes one edge after the eligible state is visible, which is two edges after the pulse that set the flag. The vector request follows one edge after the take. The bench drives its inputs on the falling edge and runs a cycle-by-cycle model of these rules. It compares every output on the next falling edge, so each result is read in the cycle it is due. Index outputs are compared only in cycles where the matching strobe is expected.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [2:0] {
    SEL_FLAG_SET = 3'd0,
    SEL_FLAG_CLR = 3'd1,
    SEL_EN       = 3'd2,
    SEL_DBG_EN   = 3'd3,
    SEL_MASK     = 3'd4,
    SEL_PROT     = 3'd5
  } wr_sel_e;

  // Position of the lowest set bit in a vector of up to 32 lines.
  function automatic logic [4:0] first_set(input logic [31:0] v);
    logic [4:0] pos;
    pos = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) pos = 5'(i);
    end
    return pos;
  endfunction

  // Lines allowed to interrupt given enables, debug state and mask.
  function automatic logic [31:0] qualify(input logic [31:0] flag,
                                          input logic [31:0] en,
                                          input logic [31:0] dbg_en,
                                          input logic        dbg_mode,
                                          input logic        mask);
    logic [31:0] allow;
    allow = en | (dbg_mode ? dbg_en : 32'd0);
    return mask ? 32'd0 : (flag & allow);
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_LINES = 12,
  parameter int IDX_W   = 4
) (
  input  logic [N_LINES-1:0] flag_i,
  input  logic [N_LINES-1:0] en_i,
  input  logic [N_LINES-1:0] dbg_en_i,
  input  logic               dbg_mode_i,
  input  logic               mask_i,
  output logic [N_LINES-1:0] elig_o,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [N_LINES-1:0] acc_o
);
  import irq_accept_pkg::*;

  logic [31:0] elig_w;

  always_comb begin
    elig_w = qualify(32'(flag_i), 32'(en_i), 32'(dbg_en_i), dbg_mode_i, mask_i);
    elig_o = elig_w[N_LINES-1:0];
    any_o  = |elig_o;
    idx_o  = IDX_W'(first_set(elig_w));
    acc_o  = any_o ? (N_LINES'(1) << idx_o) : '0;
  end

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int N_LINES = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pulse_i,
  input  logic [N_LINES-1:0] set_i,
  input  logic [N_LINES-1:0] clr_i,
  input  logic [N_LINES-1:0] acc_i,
  output logic [N_LINES-1:0] flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= ((flag_o | set_i) & ~clr_i & ~acc_i) | pulse_i;
  end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int N_LINES = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [N_LINES-1:0] wr_data_i,
  input  logic               take_i,
  input  logic [N_LINES-1:0] acc_i,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] dbg_en_o,
  output logic               mask_o,
  output logic               prot_o
);
  import irq_accept_pkg::*;

  logic wr_en_sel, wr_dbg_sel, wr_mask_sel, wr_prot_sel;

  always_comb begin
    wr_en_sel   = wr_en_i && (wr_sel_i == SEL_EN);
    wr_dbg_sel  = wr_en_i && (wr_sel_i == SEL_DBG_EN);
    wr_mask_sel = wr_en_i && (wr_sel_i == SEL_MASK);
    wr_prot_sel = wr_en_i && (wr_sel_i == SEL_PROT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o     <= '0;
      dbg_en_o <= '0;
      mask_o   <= 1'b1;
      prot_o   <= 1'b0;
    end else begin
      en_o <= (wr_en_sel ? wr_data_i : en_o) & ~acc_i;
      if (wr_dbg_sel) dbg_en_o <= wr_data_i;
      if (take_i)           mask_o <= 1'b1;
      else if (wr_mask_sel) mask_o <= wr_data_i[0];
      if (take_i)           prot_o <= 1'b0;
      else if (wr_prot_sel) prot_o <= wr_data_i[0];
    end
  end

endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int N_LINES = 12,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_pulse_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [N_LINES-1:0] wr_data_i,
  input  logic               dbg_mode_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   take_idx_o,
  output logic               vec_req_o,
  output logic [IDX_W-1:0]   vec_idx_o,
  output logic [N_LINES-1:0] flag_o,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] dbg_en_o,
  output logic               mask_o,
  output logic               prot_we_o
);
  import irq_accept_pkg::*;

  // Internal events, named so the checker can see them.
  logic [N_LINES-1:0] elig_w;
  logic               any_w;
  logic [IDX_W-1:0]   idx_w;
  logic [N_LINES-1:0] acc_w;
  logic [N_LINES-1:0] flag_set_w, flag_clr_w;

  always_comb begin
    flag_set_w = (wr_en_i && wr_sel_i == SEL_FLAG_SET) ? wr_data_i : '0;
    flag_clr_w = (wr_en_i && wr_sel_i == SEL_FLAG_CLR) ? wr_data_i : '0;
  end

  irq_arbiter #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_arb (
    .flag_i     (flag_o),
    .en_i       (en_o),
    .dbg_en_i   (dbg_en_o),
    .dbg_mode_i (dbg_mode_i),
    .mask_i     (mask_o),
    .elig_o     (elig_w),
    .any_o      (any_w),
    .idx_o      (idx_w),
    .acc_o      (acc_w)
  );

  irq_flag_reg #(.N_LINES(N_LINES)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (req_pulse_i),
    .set_i   (flag_set_w),
    .clr_i   (flag_clr_w),
    .acc_i   (acc_w),
    .flag_o  (flag_o)
  );

  irq_ctrl_regs #(.N_LINES(N_LINES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .take_i    (any_w),
    .acc_i     (acc_w),
    .en_o      (en_o),
    .dbg_en_o  (dbg_en_o),
    .mask_o    (mask_o),
    .prot_o    (prot_we_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      take_idx_o <= '0;
      vec_req_o  <= 1'b0;
      vec_idx_o  <= '0;
    end else begin
      take_o     <= any_w;
      take_idx_o <= idx_w;
      vec_req_o  <= take_o;
      vec_idx_o  <= take_idx_o;
    end
  end

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int N_LINES = 12,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] req_pulse,
  input logic [N_LINES-1:0] flag_q,
  input logic [N_LINES-1:0] en_q,
  input logic               mask_q,
  input logic               prot_q,
  input logic [N_LINES-1:0] elig,
  input logic               take,
  input logic [IDX_W-1:0]   take_idx,
  input logic               vec_req,
  input logic [IDX_W-1:0]   vec_idx
);

  p_pulse_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_pulse) |=> ((flag_q & $past(req_pulse)) == $past(req_pulse)));

  p_take_needs_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($past(!mask_q) && ((($past(flag_q) >> take_idx) & N_LINES'(1)) != '0)));

  p_take_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (mask_q && (((en_q >> take_idx) & N_LINES'(1)) == '0)));

  p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  p_take_drops_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !prot_q);

  p_vec_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (vec_req && vec_idx == $past(take_idx)));

  p_vec_only_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(take));

  p_lowest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (($past(elig) & ((N_LINES'(1) << take_idx) - N_LINES'(1))) == '0));

  p_mask_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_q) |-> !take);

endmodule

bind irq_accept irq_accept_chk #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_pulse (req_pulse_i),
  .flag_q    (flag_o),
  .en_q      (en_o),
  .mask_q    (mask_o),
  .prot_q    (prot_we_o),
  .elig      (elig_w),
  .take      (take_o),
  .take_idx  (take_idx_o),
  .vec_req   (vec_req_o),
  .vec_idx   (vec_idx_o)
);

// File: tb/irq_accept_tb.sv
`timescale 1ns/1ps
module irq_accept_tb;
  localparam int N  = 12;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pulse = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [N-1:0]  wr_data = '0;
  logic          dbg = 1'b0;
  logic          take, vreq, mask, prot;
  logic [IW-1:0] tidx, vidx;
  logic [N-1:0]  flag, en, dben;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Model state
  logic [N-1:0]  m_flag, m_en, m_dben;
  logic          m_mask, m_prot, m_take, m_vreq;
  logic [IW-1:0] m_tidx, m_vidx;

  always #2 clk = ~clk;

  irq_accept u_dut (
    .clk(clk), .rst_n(rst_n), .req_pulse_i(pulse), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .dbg_mode_i(dbg),
    .take_o(take), .take_idx_o(tidx), .vec_req_o(vreq), .vec_idx_o(vidx),
    .flag_o(flag), .en_o(en), .dbg_en_o(dben), .mask_o(mask), .prot_we_o(prot)
  );

  // Isolate lowest set bit by two's complement, then find its position.
  function automatic logic [IW-1:0] low_pos(input logic [N-1:0] v);
    logic [N-1:0] iso;
    logic [IW-1:0] p;
    iso = v & (~v + N'(1));
    p = '0;
    for (int i = 0; i < N; i++) if (iso[i]) p = IW'(i);
    return p;
  endfunction

  function automatic logic [N-1:0] model_elig();
    logic [N-1:0] ok;
    if (m_mask) return '0;
    ok = m_en;
    if (dbg) ok = ok | m_dben;
    return m_flag & ok;
  endfunction

  task automatic model_reset();
    m_flag = '0; m_en = '0; m_dben = '0; m_mask = 1'b1; m_prot = 1'b0;
    m_take = 1'b0; m_vreq = 1'b0; m_tidx = '0; m_vidx = '0;
  endtask

  task automatic model_edge();
    logic [N-1:0] e, acc;
    logic hit;
    e = model_elig();
    hit = (e != '0);
    acc = hit ? (N'(1) << low_pos(e)) : '0;
    m_vreq = m_take;
    m_vidx = m_tidx;
    m_take = hit;
    if (hit) m_tidx = low_pos(e);
    if (wr_en && wr_sel == 3'd0) m_flag = m_flag | wr_data;
    if (wr_en && wr_sel == 3'd1) m_flag = m_flag & ~wr_data;
    m_flag = (m_flag & ~acc) | pulse;
    if (wr_en && wr_sel == 3'd2) m_en = wr_data;
    m_en = m_en & ~acc;
    if (wr_en && wr_sel == 3'd3) m_dben = wr_data;
    if (hit) begin m_mask = 1'b1; m_prot = 1'b0; end
    else begin
      if (wr_en && wr_sel == 3'd4) m_mask = wr_data[0];
      if (wr_en && wr_sel == 3'd5) m_prot = wr_data[0];
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1/R8", "flag", 32'(flag), 32'(m_flag));
    chk("R4/R10", "enable", 32'(en), 32'(m_en));
    chk("R3/R10", "debug enable", 32'(dben), 32'(m_dben));
    chk("R4/R11", "mask", 32'(mask), 32'(m_mask));
    chk("R5", "prot", 32'(prot), 32'(m_prot));
    chk("R2/R3", "take", 32'(take), 32'(m_take));
    if (m_take) chk("R7", "take index", 32'(tidx), 32'(m_tidx));
    chk("R6", "vector request", 32'(vreq), 32'(m_vreq));
    if (m_vreq) chk("R6", "vector index", 32'(vidx), 32'(m_vidx));
  endtask

  // Drive inputs (already set at negedge), take one edge, compare at next negedge.
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    pulse = '0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9", "reset flag", 32'(flag), 0);
    chk("R9", "reset mask", 32'(mask), 1);
    chk("R9", "reset take", 32'(take), 0);
    chk("R9", "reset enable", 32'(en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R11: mask high blocks a pending, enabled line
    wr(3'd2, 12'h020);
    pulse = 12'h020; step();
    step(); step();
    chk("R11", "no take while masked", 32'(take), 0);
    // R2/R4/R6: clear mask, expect take of line 5 then vector
    wr(3'd5, 12'h001);
    wr(3'd4, 12'h000);
    step(); step(); step();

    // R7: lines 3 and 7 pending together, lowest first
    wr(3'd2, 12'h088);
    pulse = 12'h088; step();
    wr(3'd4, 12'h000);
    step(); step();
    chk("R7", "line 3 first when 3 and 7 pending", 32'(vidx), 3);
    wr(3'd2, 12'h080);
    wr(3'd4, 12'h000);
    step(); step();

    // R3: debug enable only, debug mode off then on
    wr(3'd3, 12'h400);
    pulse = 12'h400; step();
    wr(3'd4, 12'h000);
    step(); step();
    chk("R3", "debug enable ignored outside debug mode", 32'(take), 0);
    dbg = 1'b1; step(); step();
    dbg = 1'b0;

    // R8: new pulse on the line being taken keeps the flag
    wr(3'd2, 12'h002);
    pulse = 12'h002; step();
    wr(3'd4, 12'h000);
    pulse = 12'h002; step();
    chk("R8", "flag kept by pulse at take", 32'(flag[1]), 1);
    step();

    // R10: flag set/clear writes, pulse beats clear
    wr(3'd0, 12'h801);
    wr(3'd1, 12'h800);
    pulse = 12'h001; wr(3'd1, 12'h001);

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom();
      pulse = (r[3:0] == 4'd0) ? N'($urandom()) : '0;
      dbg = r[4];
      if (r[7:5] < 3'd3) begin
        wr_en = 1'b1;
        wr_sel = 3'($urandom_range(0, 6));
        wr_data = N'($urandom());
        if (wr_sel == 3'd4) wr_data[0] = r[8] & r[9];
      end
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule